// File: doc/BRIEF.md
# Dual-Modulus Feedback Divider

This block is the programmable feedback divider of an integer-N frequency synthesizer. It divides its input clock by N = B·P + A and emits one single-cycle pulse on `div_out` every N input cycles. It is built from three parts:

- a prescaler that divides by either P or P+1;
- a swallow counter, loaded with A, that keeps the prescaler at P+1 until it expires;
- a main counter, loaded with B, that ends each output period.

The divider input is the block's clock, and the prescaler runs on that same clock.

The modulus, A and B arrive on plain input ports. The counters sample them only when the main counter reloads, so a change made partway through a period first affects the period after it. Settings that cannot produce a valid count raise `cfg_err`. While the error is raised the divider stays idle, and once the settings are legal again it restarts from a fresh load.

Top module: `dmod_fb_divider`

## Requirements
- R1: With legal settings, the distance between consecutive `div_out` pulses is exactly B·P + A input clock cycles.
- R2: `psel` selects the prescaler base modulus P: 0 gives 8, 1 gives 16, 2 gives 32 and 3 gives 64.
- R3: Each `div_out` pulse is high for exactly one clock cycle.
- R4: With A = 0, every prescaler cycle uses modulus P, so the period is B·P.
- R5: With A = B, every prescaler cycle uses modulus P+1, so the period is B·(P+1).
- R6: Values placed on `psel`, `a_val` and `b_val` while a period is running do not change that period. They govern the period that starts at the next pulse.
- R7: `cfg_err` rises one cycle after `b_val` = 0 or `b_val` < `a_val` appears on the ports, and it falls one cycle after the condition goes away. No pulse is produced while it is high.
- R8: When settings become legal after an error, or when reset is released, the divider loads them on the next clock edge. The first pulse then follows N cycles after that load edge, which is N+1 cycles after the settings were applied.
- R9: During reset, `div_out` and `cfg_err` are both low.
- R10: The full counter ranges work, including A = 63 with B = 8191.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Divider input clock; also clocks the prescaler |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 2 | Prescaler base modulus select (P = 8 << psel) |
| a_val | input | 6 | Swallow count A |
| b_val | input | 13 | Main count B |
| div_out | output | 1 | One-cycle pulse per N input cycles |
| cfg_err | output | 1 | Settings illegal (B = 0 or B < A) |

## Verification
The table drives every modulus choice with settings chosen to tell apart the two prescaler phases:

- A = 0 exercises only the P phase.
- A = B exercises only the P+1 phase.
- A < B mixes the two, which exposes a wrong split between phases.
- B = 1 gives the shortest periods and exposes off-by-one errors in the reload.

Directed runs change the settings in mid-period to show that they take effect only at the reload, and force both illegal conditions to check the error flag and the silent output. They also measure restart latency after an error and after reset, and run the largest counter values with the smallest modulus.

// File: rtl/dmod_fb_divider.sv
module dmod_fb_divider #(
  parameter int AW    = 6,
  parameter int BW    = 13,
  parameter int SW    = 2,
  parameter int PBASE = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] psel,
  input  logic [AW-1:0] a_val,
  input  logic [BW-1:0] b_val,
  output logic          div_out,
  output logic          cfg_err
);
  localparam int PMAX = PBASE << ((1 << SW) - 1);
  localparam int PW   = $clog2(PMAX + 2);

  logic [PW-1:0] p_cur, pre_cnt, lim, p_in;
  logic [AW-1:0] a_cnt;
  logic [BW-1:0] b_cnt;
  logic          idle_q, err_q, pulse_q;
  logic          bad_in, pre_last, b_last;

  assign p_in     = PW'(PBASE) << psel;
  assign bad_in   = (b_val == '0) || (b_val < BW'(a_val));
  assign lim      = (a_cnt != '0) ? p_cur + 1'b1 : p_cur;
  assign pre_last = (pre_cnt == lim - 1'b1);
  assign b_last   = (b_cnt == BW'(1));
  assign div_out  = pulse_q;
  assign cfg_err  = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_q  <= 1'b1;
      err_q   <= 1'b0;
      pulse_q <= 1'b0;
      p_cur   <= '0;
      pre_cnt <= '0;
      a_cnt   <= '0;
      b_cnt   <= '0;
    end else begin
      err_q <= bad_in;
      if (bad_in) begin
        idle_q  <= 1'b1;
        pulse_q <= 1'b0;
      end else if (idle_q || (pre_last && b_last)) begin
        p_cur   <= p_in;
        a_cnt   <= a_val;
        b_cnt   <= b_val;
        pre_cnt <= '0;
        idle_q  <= 1'b0;
        pulse_q <= !idle_q;
      end else begin
        pulse_q <= 1'b0;
        if (pre_last) begin
          pre_cnt <= '0;
          b_cnt   <= b_cnt - 1'b1;
          if (a_cnt != '0) a_cnt <= a_cnt - 1'b1;
        end else begin
          pre_cnt <= pre_cnt + 1'b1;
        end
      end
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) div_out |=> !div_out); // R3
  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n) cfg_err |-> !div_out); // R7
  AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n) !idle_q |-> (pre_cnt < lim)); // R1
  AST_SWALLOW_LE_MAIN: assert property (@(posedge clk) disable iff (!rst_n) !idle_q |-> (BW'(a_cnt) <= b_cnt)); // R1
  AST_MAIN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) !idle_q |-> (b_cnt != '0)); // R1
  AST_PULSE_AT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n) div_out |-> (pre_cnt == '0 && !idle_q)); // R1
endmodule

// File: tb/test_dmod_fb_divider.sv
module test_dmod_fb_divider;
  typedef struct packed {
    logic [1:0]  ps;
    logic [5:0]  a;
    logic [12:0] b;
    logic [19:0] n;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{2'd0, 6'd0,  13'd1,   20'd8},    // R4 shortest, P only
    '{2'd0, 6'd1,  13'd1,   20'd9},    // R5 shortest, P+1 only
    '{2'd1, 6'd5,  13'd20,  20'd325},  // R1 mixed
    '{2'd2, 6'd0,  13'd31,  20'd992},  // R4 smallest contiguous N for P=32
    '{2'd2, 6'd31, 13'd40,  20'd1311}, // R1 mixed
    '{2'd3, 6'd63, 13'd63,  20'd4095}, // R5 P=64
    '{2'd3, 6'd10, 13'd100, 20'd6410}, // R2 mixed
    '{2'd1, 6'd15, 13'd15,  20'd255}   // R5 P=16
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  psel;
  logic [5:0]  a_val;
  logic [12:0] b_val;
  logic        div_out, cfg_err;
  int total = 0, bad = 0, cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dmod_fb_divider i_dmod_fb_divider (
    .clk(clk), .rst_n(rst_n), .psel(psel), .a_val(a_val), .b_val(b_val),
    .div_out(div_out), .cfg_err(cfg_err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_pulse(output int t);
    int guard = 0;
    @(negedge clk);
    while (!div_out && guard < 300000) begin
      @(negedge clk);
      guard++;
    end
    t = cyc;
  endtask

  task automatic set_cfg(input logic [1:0] p, input logic [5:0] a, input logic [12:0] b);
    psel = p; a_val = a; b_val = b;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int t0, t1, t2, ta, hits;
    rst_n = 1'b0;
    set_cfg(2'd0, 6'd0, 13'd1);
    repeat (3) @(negedge clk);
    check(div_out == 0 && cfg_err == 0, "R9 reset outputs", {div_out, cfg_err}, 0);
    rst_n = 1'b1;
    ta = cyc;
    wait_pulse(t0);
    check(t0 - ta == 9, "R8 first pulse after reset", t0 - ta, 9);
    @(negedge clk);
    check(div_out == 0, "R3 pulse width", div_out, 0);
    wait_pulse(t1);
    check(t1 - t0 == 8, "R1 P=8 B=1 period", t1 - t0, 8);

    for (int i = 0; i < 8; i++) begin
      set_cfg(VEC[i].ps, VEC[i].a, VEC[i].b);
      wait_pulse(t0);
      wait_pulse(t1);
      check(t1 - t0 == int'(VEC[i].n), $sformatf("R1 R2 vector %0d period", i), t1 - t0, int'(VEC[i].n));
    end

    set_cfg(2'd1, 6'd2, 13'd3);
    wait_pulse(t0);
    set_cfg(2'd0, 6'd0, 13'd2);
    wait_pulse(t1);
    check(t1 - t0 == 50, "R6 running period kept", t1 - t0, 50);
    wait_pulse(t2);
    check(t2 - t1 == 16, "R6 new period after reload", t2 - t1, 16);

    set_cfg(2'd0, 6'd0, 13'd0);
    @(negedge clk);
    check(cfg_err == 1 && div_out == 0, "R7 B zero flagged", cfg_err, 1);
    set_cfg(2'd0, 6'd5, 13'd3);
    @(negedge clk);
    check(cfg_err == 1, "R7 B below A flagged", cfg_err, 1);
    hits = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (div_out) hits++;
    end
    check(hits == 0, "R7 no pulses during error", hits, 0);

    set_cfg(2'd0, 6'd63, 13'd8191);
    ta = cyc;
    @(negedge clk);
    check(cfg_err == 0, "R7 flag clears", cfg_err, 0);
    while (!div_out) @(negedge clk);
    t0 = cyc;
    check(t0 - ta == 65592, "R8 R10 restart latency at max counts", t0 - ta, 65592);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule